// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 style management transactions towards an Ethernet PHY. It reads and writes one 16-bit PHY register per request. It derives the management clock from the system clock through a configurable divider. It drives the shared data line through an output value and an output-enable, and it takes the line's level back in through a small synchronizer. A host pulses a start strobe along with a direction bit, a PHY address, a register address and, for writes, a data word. The block raises busy until it returns a single-cycle done pulse together with read data and an error flag.

Every transaction is 65 management clock slots long, whether it reads or writes. A read whose acknowledge sample comes back high still clocks the complete data phase, so that the PHY stays in step, and then reports an error with zero data. An address guard can be enabled: when the configuration input is low, only PHY address 24 is reachable. Any other address completes at once with an error and never toggles the management pins.

Top module: `mdio_master`

## Requirements
- R1: Each accepted transaction starts with 32 management clock slots (slots 0 to 31) in which the data line is driven high.
- R2: Slots 32 to 45 drive the start code 01, then the opcode (10 for read, 01 for write), then the 5-bit PHY address, then the 5-bit register address, each field MSB first.
- R3: A write then drives the turnaround 10 (slots 46 to 47), the 16 data bits MSB first (slots 48 to 63) and a high idle slot 64, releases the line after it, and completes with error 0 and read data 0.
- R4: A read drives a low idle slot 46 and releases the line from slot 47 to the end. The level sampled in slot 47 is the acknowledge, and low means the PHY answered.
- R5: On an answered read, the bits sampled in slots 48 to 63 form the read data MSB first, slot 64 is a trailing clock, and the error flag is 0.
- R6: On a read whose acknowledge is high, all 65 slots are still clocked, nothing is captured, and the block completes with error 1 and read data 0.
- R7: The management clock is low while idle and has a half period of CLK_HALF system cycles. The driven data value and its enable change only at falling management clock edges, never at a rising one.
- R8: busy rises in the cycle after an accepted start and stays high through the single done cycle. An addressed transaction keeps busy high for 130*CLK_HALF+1 cycles.
- R9: A start request while busy is ignored, including one in the done cycle. The ongoing frame is unchanged and no new transaction follows.
- R10: With cfg_any_phy low and a PHY address other than 24, the request completes with done one cycle after the start, error 1 and read data 0, without any management clock edge or driven data. Address 24, or cfg_any_phy high, proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_any_phy | input | 1 | High: every PHY address allowed; low: only address 24 |
| req_start | input | 1 | Start pulse for a transaction |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data, valid at done |
| rsp_err | output | 1 | Missing acknowledge or refused address, valid at done |
| rsp_done | output | 1 | Single-cycle completion pulse |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line level as seen at the pad |

## Verification
The completion pulse and the acceptance of a new request can meet in the same cycle. When done is high, busy is still high, so a start raised in that cycle must be dropped. The bench waits for done, raises start in that very cycle, and then watches busy and the management clock for forty cycles, where any activity fails R9. A second start pulse is also injected in the middle of a frame, and the scoreboard's full slot-by-slot comparison of that frame shows that it was left untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int PRE_SLOTS = 32;
  localparam int HDR_BITS  = 2 + 2 + 2 * ADDR_W;
  localparam int N_SLOTS   = PRE_SLOTS + HDR_BITS + 2 + DATA_W + 1;
  localparam int SLOT_W    = $clog2(N_SLOTS + 1);

  localparam logic [SLOT_W-1:0] SL_HDR_END = SLOT_W'(PRE_SLOTS + HDR_BITS - 1);
  localparam logic [SLOT_W-1:0] SL_TA0     = SLOT_W'(PRE_SLOTS + HDR_BITS);
  localparam logic [SLOT_W-1:0] SL_TA1     = SLOT_W'(PRE_SLOTS + HDR_BITS + 1);
  localparam logic [SLOT_W-1:0] SL_DAT_END = SLOT_W'(PRE_SLOTS + HDR_BITS + 1 + DATA_W);
  localparam logic [SLOT_W-1:0] SL_LAST    = SLOT_W'(N_SLOTS - 1);

  localparam logic [1:0]        START_CODE = 2'b01;
  localparam logic [1:0]        OP_READ    = 2'b10;
  localparam logic [1:0]        OP_WRITE   = 2'b01;
  localparam logic [1:0]        TA_WRITE   = 2'b10;
  localparam logic [ADDR_W-1:0] GUARD_PHY  = ADDR_W'(24);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic oe;
    logic d;
  } pin_drive_t;

  function automatic pin_drive_t slot_drive(
    input logic                wr,
    input logic [SLOT_W-1:0]   slot,
    input logic [HDR_BITS-1:0] hdr,
    input logic [DATA_W-1:0]   wdata
  );
    pin_drive_t          r;
    logic [SLOT_W-1:0]   idx;
    r = '{oe: 1'b1, d: 1'b1};
    idx = '0;
    if (slot < SLOT_W'(PRE_SLOTS)) begin
      r = '{oe: 1'b1, d: 1'b1};
    end else if (slot <= SL_HDR_END) begin
      idx = SL_HDR_END - slot;
      r = '{oe: 1'b1, d: hdr[idx[$clog2(HDR_BITS)-1:0]]};
    end else if (wr) begin
      if (slot == SL_TA0) begin
        r = '{oe: 1'b1, d: TA_WRITE[1]};
      end else if (slot == SL_TA1) begin
        r = '{oe: 1'b1, d: TA_WRITE[0]};
      end else if (slot <= SL_DAT_END) begin
        idx = SL_DAT_END - slot;
        r = '{oe: 1'b1, d: wdata[idx[$clog2(DATA_W)-1:0]]};
      end else begin
        r = '{oe: 1'b1, d: 1'b1};
      end
    end else begin
      if (slot == SL_TA0) begin
        r = '{oe: 1'b1, d: 1'b0};
      end else begin
        r = '{oe: 1'b0, d: 1'b1};
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= d_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CLK_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);

  localparam int CNT_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CLK_HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             tick;

  assign tick = run && (cnt_q == CNT_TOP);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = tick && !mdc_q;
  assign fall_stb = tick && mdc_q;

  // R7: the clock settles low once the sequencer stops it
  p_mdc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);

  // R7: the clock only toggles while running
  p_mdc_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc != $past(mdc)) |-> $past(run));

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_any_phy,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              line_in,
  output logic              run,
  output logic              drv_out,
  output logic              drv_oe,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_done,
  output logic              busy
);

  seq_state_e          state_q, state_d;
  logic [SLOT_W-1:0]   slot_q, slot_d;
  logic                wr_q, wr_d;
  logic [HDR_BITS-1:0] hdr_q, hdr_d;
  logic [DATA_W-1:0]   wdata_q, wdata_d;
  logic [DATA_W-1:0]   rdata_q, rdata_d;
  logic                err_q, err_d;
  logic                nak_q, nak_d;
  logic                out_q, out_d;
  logic                oe_q, oe_d;
  logic                refused;
  logic                in_data;
  pin_drive_t          first_drv, next_drv;

  assign refused   = !cfg_any_phy && (req_phy != GUARD_PHY);
  assign in_data   = (slot_q > SL_TA1) && (slot_q <= SL_DAT_END);
  assign first_drv = slot_drive(req_write, '0, '0, '0);
  assign next_drv  = slot_drive(wr_q, slot_q + SLOT_W'(1), hdr_q, wdata_q);

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    wr_d    = wr_q;
    hdr_d   = hdr_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    err_d   = err_q;
    nak_d   = nak_q;
    out_d   = out_q;
    oe_d    = oe_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_start) begin
          rdata_d = '0;
          if (refused) begin
            state_d = ST_DONE;
            err_d   = 1'b1;
          end else begin
            state_d = ST_SHIFT;
            slot_d  = '0;
            wr_d    = req_write;
            hdr_d   = {START_CODE, req_write ? OP_WRITE : OP_READ, req_phy, req_reg};
            wdata_d = req_wdata;
            err_d   = 1'b0;
            nak_d   = 1'b0;
            out_d   = first_drv.d;
            oe_d    = first_drv.oe;
          end
        end
      end
      ST_SHIFT: begin
        if (rise_stb && !wr_q) begin
          if (slot_q == SL_TA1) begin
            nak_d = line_in;
          end else if (in_data && !nak_q) begin
            rdata_d = {rdata_q[DATA_W-2:0], line_in};
          end
        end
        if (fall_stb) begin
          if (slot_q == SL_LAST) begin
            state_d = ST_DONE;
            err_d   = !wr_q && nak_q;
            out_d   = 1'b1;
            oe_d    = 1'b0;
          end else begin
            slot_d  = slot_q + SLOT_W'(1);
            out_d   = next_drv.d;
            oe_d    = next_drv.oe;
          end
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      wr_q    <= 1'b0;
      hdr_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      nak_q   <= 1'b0;
      out_q   <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      wr_q    <= wr_d;
      hdr_q   <= hdr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
      nak_q   <= nak_d;
      out_q   <= out_d;
      oe_q    <= oe_d;
    end
  end

  assign run       = (state_q == ST_SHIFT);
  assign drv_out   = out_q;
  assign drv_oe    = oe_q;
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;
  assign rsp_done  = (state_q == ST_DONE);
  assign busy      = (state_q != ST_IDLE);

  // R8: done lasts one cycle and always falls inside busy
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> busy);
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_done) |=> busy);

  // R9: a start raised in the done cycle never opens a new transaction
  p_done_then_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !busy);

  // R10: a guarded address completes in the next cycle
  p_guard_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_start && !cfg_any_phy && (req_phy != GUARD_PHY)) |=> rsp_done);

  // R3: the line is released whenever no transaction runs
  p_release_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !drv_oe);

  // R6: an error always comes with zero data
  p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> (rsp_rdata == '0));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_any_phy,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_done,
  output logic              busy,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);

  logic line_s;
  logic run;
  logic rise_stb;
  logic fall_stb;

  mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (mdio_in),
    .d_out (line_s)
  );

  mdio_clkgen #(.CLK_HALF(CLK_HALF)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_any_phy (cfg_any_phy),
    .req_start   (req_start),
    .req_write   (req_write),
    .req_phy     (req_phy),
    .req_reg     (req_reg),
    .req_wdata   (req_wdata),
    .rise_stb    (rise_stb),
    .fall_stb    (fall_stb),
    .line_in     (line_s),
    .run         (run),
    .drv_out     (mdio_out),
    .drv_oe      (mdio_oe),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err),
    .rsp_done    (rsp_done),
    .busy        (busy)
  );

  // R7: pins never move on a rising management clock edge
  p_drive_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_out) && $stable(mdio_oe)));

  // R7: no management clock activity outside a transaction
  p_mdc_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> busy);

endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  import mdio_pkg::*;

  localparam int HALF     = 4;
  localparam int BUSY_LEN = 130 * HALF + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_any_phy = 1'b1;
  logic        req_start = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rsp_rdata;
  logic        rsp_err, rsp_done, busy, mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  always #4 clk = ~clk;

  mdio_master #(.CLK_HALF(HALF)) i_mdio_master (
    .clk(clk), .rst_n(rst_n), .cfg_any_phy(cfg_any_phy),
    .req_start(req_start), .req_write(req_write), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .rsp_done(rsp_done), .busy(busy), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  typedef struct {
    bit        wr;
    bit [4:0]  phy;
    bit [4:0]  rg;
    bit [15:0] wd;
    bit        ack_ok;
    bit [15:0] pd;
    bit        refused;
  } item_t;

  item_t q[$];
  int    n_chk = 0, n_fail = 0;
  int    rise_n = 0, busy_n = 0;
  bit    oe_seen = 0, mdc_prev = 0;
  bit    cap_oe[65];
  bit    cap_d[65];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic evaluate(input item_t it);
    bit [64:0] wvec;
    bit [46:0] rvec;
    int        bad_pre, bad_hdr, bad_tail;
    bit        e_oe, e_d;
    bad_pre = 0; bad_hdr = 0; bad_tail = 0;
    if (it.refused) begin
      check(rise_n == 0, "R10", "mdc rises on refused access", rise_n, 0);
      check(!oe_seen, "R10", "line driven on refused access", oe_seen, 0);
      check(busy_n == 1, "R10", "busy cycles on refused access", busy_n, 1);
      check(rsp_err == 1'b1, "R10", "refused error flag", rsp_err, 1);
      check(rsp_rdata == 16'h0, "R10", "refused read data", rsp_rdata, 0);
      return;
    end
    wvec = {32'hFFFF_FFFF, 2'b01, 2'b01, it.phy, it.rg, 2'b10, it.wd, 1'b1};
    rvec = {32'hFFFF_FFFF, 2'b01, 2'b10, it.phy, it.rg, 1'b0};
    for (int k = 0; k < 65; k++) begin
      if (it.wr) begin
        e_oe = 1'b1; e_d = wvec[64-k];
      end else if (k < 47) begin
        e_oe = 1'b1; e_d = rvec[46-k];
      end else begin
        e_oe = 1'b0; e_d = cap_d[k];
      end
      if (cap_oe[k] != e_oe || cap_d[k] != e_d) begin
        if (k < 32)      bad_pre++;
        else if (k < 46) bad_hdr++;
        else             bad_tail++;
      end
    end
    check(rise_n == 65, "R6", "management clock rises per frame", rise_n, 65);
    check(bad_pre == 0, "R1", "preamble slot mismatches", bad_pre, 0);
    check(bad_hdr == 0, "R2", "header slot mismatches", bad_hdr, 0);
    if (it.wr) check(bad_tail == 0, "R3", "write tail slot mismatches", bad_tail, 0);
    else       check(bad_tail == 0, "R4", "read tail slot mismatches", bad_tail, 0);
    check(busy_n == BUSY_LEN, "R8", "busy cycles", busy_n, BUSY_LEN);
    if (it.wr) begin
      check(rsp_err == 1'b0, "R3", "write error flag", rsp_err, 0);
      check(rsp_rdata == 16'h0, "R3", "write read data", rsp_rdata, 0);
    end else if (it.ack_ok) begin
      check(rsp_err == 1'b0, "R5", "read error flag", rsp_err, 0);
      check(rsp_rdata == it.pd, "R5", "read data", rsp_rdata, it.pd);
    end else begin
      check(rsp_err == 1'b1, "R6", "no-ack error flag", rsp_err, 1);
      check(rsp_rdata == 16'h0, "R6", "no-ack read data", rsp_rdata, 0);
    end
  endtask

  // monitor and PHY responder
  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc && !mdc_prev) begin
        if (rise_n < 65) begin
          cap_oe[rise_n] = mdio_oe;
          cap_d[rise_n]  = mdio_out;
        end
        if (q.size() > 0 && !q[0].wr && !q[0].refused) begin
          if (rise_n == 46)
            mdio_in = q[0].ack_ok ? 1'b0 : 1'b1;
          else if (rise_n >= 47 && rise_n <= 62 && q[0].ack_ok)
            mdio_in = q[0].pd[62-rise_n];
          else
            mdio_in = 1'b1;
        end else begin
          mdio_in = 1'b1;
        end
        rise_n++;
      end
      mdc_prev = mdc;
      if (busy) busy_n++;
      if (mdio_oe) oe_seen = 1'b1;
      if (rsp_done) begin
        if (q.size() == 0) begin
          check(1'b0, "R8", "done without pending request", 1, 0);
        end else begin
          evaluate(q.pop_front());
        end
        rise_n = 0; busy_n = 0; oe_seen = 1'b0; mdio_in = 1'b1;
      end
    end
  end

  task automatic issue(input bit wr, input bit [4:0] phy, input bit [4:0] rg,
                       input bit [15:0] wd, input bit ack_ok, input bit [15:0] pd,
                       input bit poke_mid);
    item_t it;
    it.wr = wr; it.phy = phy; it.rg = rg; it.wd = wd;
    it.ack_ok = ack_ok; it.pd = pd;
    it.refused = !cfg_any_phy && (phy != 5'd24);
    q.push_back(it);
    @(negedge clk);
    req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    if (poke_mid) begin
      repeat (100) @(negedge clk);
      // R9: start pulse with other fields in the middle of a frame
      req_write = !wr; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R8: watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int extra_busy, extra_rise;
    bit prev;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && rsp_done == 1'b0, "R8", "reset busy/done", {busy, rsp_done}, 0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R7", "reset mdc/oe", {mdc, mdio_oe}, 0);
    check(rsp_rdata == 16'h0 && rsp_err == 1'b0, "R5", "reset rdata/err", {rsp_err, rsp_rdata}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    cfg_any_phy = 1'b1;
    issue(1'b1, 5'd3,  5'd17, 16'hA5C3, 1'b1, 16'h0000, 1'b0);
    issue(1'b0, 5'd7,  5'd2,  16'h0000, 1'b1, 16'h8001, 1'b0);
    issue(1'b0, 5'd31, 5'd31, 16'h0000, 1'b0, 16'hFFFF, 1'b0);
    issue(1'b0, 5'd0,  5'd0,  16'h0000, 1'b1, 16'h5A3C, 1'b0);

    cfg_any_phy = 1'b0;
    issue(1'b0, 5'd5,  5'd1,  16'h0000, 1'b1, 16'h1111, 1'b0);
    issue(1'b1, 5'd0,  5'd4,  16'hBEEF, 1'b1, 16'h0000, 1'b0);
    issue(1'b0, 5'd24, 5'd1,  16'h0000, 1'b1, 16'h1234, 1'b0);
    issue(1'b1, 5'd24, 5'd9,  16'h0F0F, 1'b1, 16'h0000, 1'b0);

    cfg_any_phy = 1'b1;
    issue(1'b1, 5'd10, 5'd20, 16'h0001, 1'b1, 16'h0000, 1'b1);

    // R9: start raised in the done cycle
    begin
      item_t it;
      it.wr = 1'b0; it.phy = 5'd12; it.rg = 5'd6; it.wd = '0;
      it.ack_ok = 1'b1; it.pd = 16'hC0DE; it.refused = 1'b0;
      q.push_back(it);
      @(negedge clk);
      req_write = 1'b0; req_phy = 5'd12; req_reg = 5'd6; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      do @(negedge clk); while (!rsp_done);
      req_start = 1'b1; req_write = 1'b1; req_phy = 5'd1;
      @(negedge clk);
      req_start = 1'b0;
      extra_busy = 0; extra_rise = 0; prev = mdc;
      for (int c = 0; c < 40; c++) begin
        if (busy) extra_busy++;
        if (mdc && !prev) extra_rise++;
        prev = mdc;
        @(negedge clk);
      end
      check(extra_busy == 0, "R9", "busy after done-cycle start", extra_busy, 0);
      check(extra_rise == 0, "R9", "mdc rises after done-cycle start", extra_rise, 0);
    end

    finish_run();
  end

endmodule